// File: doc/BRIEF.md
# UART Channel Control and Mode Register Front End

This block is the register front end of one UART channel. A byte-wide synchronous register bus writes a command byte, a set of mode bytes reached through an internal pointer, and a clock-select byte. It reads back the mode bytes, the channel enables, and a status byte built from flags that the serializer core supplies. The block holds the frame format (character length, parity, stop length, FIFO and baud-extension settings) and the receiver and transmitter enables. It gives the serializer core one-cycle pulses that reset the receiver, the transmitter, the error flags and the break-change flag, and pulses that start or stop a break.

The command byte has two parts. The low nibble carries enable and disable bits for each direction. The high nibble carries a command code. Both parts act together in one write. Mode writes go to the byte that the pointer selects. The pointer then moves from the first mode byte to the second. A separate code moves the pointer to the extra mode byte that holds the FIFO and baud-extension controls.

Top module: `uart_chan_regs`

## Requirements
- R1: After reset, both enables are 0, every strobe output is 0, all three mode bytes are 0x00, and the mode pointer selects the first mode byte (MR1).
- R2: A write to offset 2 enables the receiver when bit 0 is set and disables it when bit 1 is set. It enables the transmitter when bit 2 is set and disables it when bit 3 is set. When a direction has both its enable bit and its disable bit set, it is disabled. The new enable is visible one cycle after the write. Any other write leaves the enables unchanged.
- R3: Command codes in bits 7:4 of a write to offset 2 each give a pulse one cycle long, in the cycle after the write: 2 pulses rx_reset_o, 3 pulses tx_reset_o, 4 pulses err_reset_o, 5 pulses brk_chg_reset_o, 6 pulses brk_start_o, and 7 pulses brk_stop_o. No other code drives any of these outputs.
- R4: Code 2 clears the receiver enable and code 3 clears the transmitter enable. This holds even when the same write sets the enable bit for that direction.
- R5: Code 1 moves the pointer to MR1. A write to offset 0 while the pointer is at MR1 stores the byte in MR1 and moves the pointer to MR2. Each further write to offset 0 stores the byte in MR2, and the pointer stays at MR2.
- R6: Code 0xB moves the pointer to MR0. A write to offset 0 while the pointer is at MR0 stores the byte in MR0 and moves the pointer to MR1.
- R7: The outputs decode the mode bytes as follows. char_len_o is MR1 bits 1:0. parity_mode_o is MR1 bits 4:2. stop_sel_o is MR2 bits 3:0. baud_ext_o is MR0 bits 2:0. fifo_en_o is MR0 bit 3. tx_half_lvl_o is MR0 bit 4.
- R8: A read of offset 1 returns the status byte. Bit 0 is rx ready, bit 1 is FIFO full, bit 2 is tx ready, bit 3 is tx empty, bit 4 is overrun, bit 5 is parity error, bit 6 is framing error and bit 7 is received break. rdata_o takes the value one cycle after the read strobe and holds it until the next read.
- R9: A read of offset 0 returns the mode byte that the pointer selects and does not move the pointer. A read of offset 2 returns {6'b0, tx enable, rx enable}.
- R10: A write to offset 3 gives a one-cycle tx_push_o pulse, and tx_data_o holds the written byte. A read of offset 3 gives a one-cycle rx_pop_o pulse and returns rx_data_i. A write to offset 1 stores the byte on clk_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, registered |
| rx_rdy_i | input | 1 | Receive data available |
| fifo_full_i | input | 1 | Receive FIFO full |
| tx_rdy_i | input | 1 | Transmit holding has room |
| tx_empty_i | input | 1 | Transmitter idle |
| overrun_i | input | 1 | Receive overrun flag |
| par_err_i | input | 1 | Parity error flag |
| frm_err_i | input | 1 | Framing error flag |
| rx_brk_i | input | 1 | Received break flag |
| rx_data_i | input | DW | Receive holding byte |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_reset_o | output | 1 | Receiver reset pulse |
| tx_reset_o | output | 1 | Transmitter reset pulse |
| err_reset_o | output | 1 | Error status reset pulse |
| brk_chg_reset_o | output | 1 | Break-change reset pulse |
| brk_start_o | output | 1 | Start break pulse |
| brk_stop_o | output | 1 | Stop break pulse |
| char_len_o | output | 2 | Character length code |
| parity_mode_o | output | 3 | Parity mode code |
| stop_sel_o | output | 4 | Stop length code |
| baud_ext_o | output | 3 | Extended baud mode |
| fifo_en_o | output | 1 | FIFO enable |
| tx_half_lvl_o | output | 1 | Half-full transmit level select |
| clk_sel_o | output | DW | Clock-select byte |
| tx_push_o | output | 1 | Transmit holding write pulse |
| tx_data_o | output | DW | Transmit byte |
| rx_pop_o | output | 1 | Receive holding read pulse |

## Verification
Every result appears exactly one clock edge after the bus strobe that causes it. This covers the enables, the mode fields, the pointer move, the read data and every pulse. The bench drives each access on a falling edge, lets one rising edge capture it, and checks the outputs on the next falling edge. It then idles one cycle and checks that every pulse has dropped. The status flags are set before the read edge and checked in the byte that comes back. The pointer is checked through later mode reads and writes rather than through internal state.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;
  typedef enum logic [1:0] {PTR_MR0 = 2'd0, PTR_MR1 = 2'd1, PTR_MR2 = 2'd2} mr_ptr_e;

  localparam logic [1:0] OFS_MODE = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_CMD  = 2'd2;
  localparam logic [1:0] OFS_DATA = 2'd3;

  localparam logic [3:0] CMD_PTR_MR1 = 4'h1;
  localparam logic [3:0] CMD_RX_RST  = 4'h2;
  localparam logic [3:0] CMD_TX_RST  = 4'h3;
  localparam logic [3:0] CMD_ERR_RST = 4'h4;
  localparam logic [3:0] CMD_CHG_RST = 4'h5;
  localparam logic [3:0] CMD_BRK_ON  = 4'h6;
  localparam logic [3:0] CMD_BRK_OFF = 4'h7;
  localparam logic [3:0] CMD_PTR_MR0 = 4'hB;

  typedef struct packed {
    logic rx_rst;
    logic tx_rst;
    logic err_rst;
    logic chg_rst;
    logic brk_on;
    logic brk_off;
  } strobe_t;
endpackage

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
  import uart_chan_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NDIR = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_wr_i,
  input  logic [DW-1:0]   cmd_i,
  output logic [NDIR-1:0] en_o,
  output strobe_t         strb_o,
  output logic            ptr_mr1_o,
  output logic            ptr_mr0_o
);
  localparam int CW = 4;
  logic [CW-1:0] code;
  assign code = cmd_i[DW-1 -: CW];

  // dir 0 = receiver, dir 1 = transmitter; disable and reset dominate enable
  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    logic en_q, kill, set;
    assign kill = cmd_wr_i && (cmd_i[2*g+1] || code == ((g == 0) ? CMD_RX_RST : CMD_TX_RST));
    assign set  = cmd_wr_i && cmd_i[2*g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q <= 1'b0;
      else if (kill) en_q <= 1'b0;
      else if (set)  en_q <= 1'b1;
    end
    assign en_o[g] = en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_o <= '0;
    end else begin
      strb_o.rx_rst  <= cmd_wr_i && code == CMD_RX_RST;
      strb_o.tx_rst  <= cmd_wr_i && code == CMD_TX_RST;
      strb_o.err_rst <= cmd_wr_i && code == CMD_ERR_RST;
      strb_o.chg_rst <= cmd_wr_i && code == CMD_CHG_RST;
      strb_o.brk_on  <= cmd_wr_i && code == CMD_BRK_ON;
      strb_o.brk_off <= cmd_wr_i && code == CMD_BRK_OFF;
    end
  end

  assign ptr_mr1_o = cmd_wr_i && code == CMD_PTR_MR1;
  assign ptr_mr0_o = cmd_wr_i && code == CMD_PTR_MR0;
endmodule

// File: rtl/uart_mode_regs.sv
module uart_mode_regs
  import uart_chan_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ptr_mr1_i,
  input  logic          ptr_mr0_i,
  output logic [DW-1:0] mr0_o,
  output logic [DW-1:0] mr1_o,
  output logic [DW-1:0] mr2_o,
  output logic [DW-1:0] cur_o
);
  mr_ptr_e ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= PTR_MR1;
      mr0_o <= '0;
      mr1_o <= '0;
      mr2_o <= '0;
    end else if (ptr_mr1_i) begin
      ptr_q <= PTR_MR1;
    end else if (ptr_mr0_i) begin
      ptr_q <= PTR_MR0;
    end else if (mode_wr_i) begin
      unique case (ptr_q)
        PTR_MR0: begin mr0_o <= wdata_i; ptr_q <= PTR_MR1; end
        PTR_MR1: begin mr1_o <= wdata_i; ptr_q <= PTR_MR2; end
        default: mr2_o <= wdata_i;
      endcase
    end
  end

  always_comb begin
    unique case (ptr_q)
      PTR_MR0: cur_o = mr0_o;
      PTR_MR1: cur_o = mr1_o;
      default: cur_o = mr2_o;
    endcase
  end
endmodule

// File: rtl/uart_read_mux.sv
module uart_read_mux
  import uart_chan_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     status_i,
  input  logic [DW-1:0]     mode_i,
  input  logic [DW-1:0]     ctrl_i,
  input  logic [DW-1:0]     rx_data_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rx_pop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rx_pop_o <= 1'b0;
    end else begin
      rx_pop_o <= rd_i && addr_i == ADDR_W'(OFS_DATA);
      if (rd_i) begin
        if      (addr_i == ADDR_W'(OFS_MODE)) rdata_o <= mode_i;
        else if (addr_i == ADDR_W'(OFS_STAT)) rdata_o <= status_i;
        else if (addr_i == ADDR_W'(OFS_CMD))  rdata_o <= ctrl_i;
        else                                  rdata_o <= rx_data_i;
      end
    end
  end
endmodule

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
  import uart_chan_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              rx_rdy_i,
  input  logic              fifo_full_i,
  input  logic              tx_rdy_i,
  input  logic              tx_empty_i,
  input  logic              overrun_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              rx_brk_i,
  input  logic [DW-1:0]     rx_data_i,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              rx_reset_o,
  output logic              tx_reset_o,
  output logic              err_reset_o,
  output logic              brk_chg_reset_o,
  output logic              brk_start_o,
  output logic              brk_stop_o,
  output logic [1:0]        char_len_o,
  output logic [2:0]        parity_mode_o,
  output logic [3:0]        stop_sel_o,
  output logic [2:0]        baud_ext_o,
  output logic              fifo_en_o,
  output logic              tx_half_lvl_o,
  output logic [DW-1:0]     clk_sel_o,
  output logic              tx_push_o,
  output logic [DW-1:0]     tx_data_o,
  output logic              rx_pop_o
);
  localparam int NDIR = 2;

  logic            cmd_wr, mode_wr, ptr_mr1, ptr_mr0;
  logic [NDIR-1:0] en;
  strobe_t         strb;
  logic [DW-1:0]   mr0, mr1, mr2, mr_cur, status, ctrl;

  assign cmd_wr  = wr_i && addr_i == ADDR_W'(OFS_CMD);
  assign mode_wr = wr_i && addr_i == ADDR_W'(OFS_MODE);

  uart_cmd_dec #(.DW(DW), .NDIR(NDIR)) u_cmd (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .cmd_i(wdata_i),
    .en_o(en), .strb_o(strb), .ptr_mr1_o(ptr_mr1), .ptr_mr0_o(ptr_mr0)
  );

  uart_mode_regs #(.DW(DW)) u_mode (
    .clk_i, .rst_ni, .mode_wr_i(mode_wr), .wdata_i,
    .ptr_mr1_i(ptr_mr1), .ptr_mr0_i(ptr_mr0),
    .mr0_o(mr0), .mr1_o(mr1), .mr2_o(mr2), .cur_o(mr_cur)
  );

  assign status = DW'({rx_brk_i, frm_err_i, par_err_i, overrun_i,
                       tx_empty_i, tx_rdy_i, fifo_full_i, rx_rdy_i});
  assign ctrl   = DW'(en);

  uart_read_mux #(.DW(DW), .ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni, .rd_i, .addr_i, .status_i(status), .mode_i(mr_cur),
    .ctrl_i(ctrl), .rx_data_i, .rdata_o, .rx_pop_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_o <= '0;
      tx_data_o <= '0;
      tx_push_o <= 1'b0;
    end else begin
      tx_push_o <= wr_i && addr_i == ADDR_W'(OFS_DATA);
      if (wr_i && addr_i == ADDR_W'(OFS_DATA)) tx_data_o <= wdata_i;
      if (wr_i && addr_i == ADDR_W'(OFS_STAT)) clk_sel_o <= wdata_i;
    end
  end

  assign rx_en_o         = en[0];
  assign tx_en_o         = en[1];
  assign rx_reset_o      = strb.rx_rst;
  assign tx_reset_o      = strb.tx_rst;
  assign err_reset_o     = strb.err_rst;
  assign brk_chg_reset_o = strb.chg_rst;
  assign brk_start_o     = strb.brk_on;
  assign brk_stop_o      = strb.brk_off;
  assign char_len_o      = mr1[1:0];
  assign parity_mode_o   = mr1[4:2];
  assign stop_sel_o      = mr2[3:0];
  assign baud_ext_o      = mr0[2:0];
  assign fifo_en_o       = mr0[3];
  assign tx_half_lvl_o   = mr0[4];
endmodule

// File: rtl/uart_chan_regs_chk.sv
module uart_chan_regs_chk
  import uart_chan_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              rx_en_o,
  input logic              tx_en_o,
  input logic              rx_reset_o,
  input logic              tx_reset_o,
  input logic              err_reset_o,
  input logic              brk_chg_reset_o,
  input logic              brk_start_o,
  input logic              brk_stop_o,
  input logic              tx_push_o
);
  logic cmd_wr;
  assign cmd_wr = wr_i && addr_i == ADDR_W'(OFS_CMD);

  // R3
  rx_rst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_reset_o |-> $past(cmd_wr && wdata_i[DW-1 -: 4] == CMD_RX_RST));

  // R3
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_reset_o, tx_reset_o, err_reset_o, brk_chg_reset_o, brk_start_o, brk_stop_o}));

  // R4
  rx_rst_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_reset_o |-> !rx_en_o);

  // R4
  tx_rst_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_reset_o |-> !tx_en_o);

  // R2
  rx_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[1]) |=> !rx_en_o);

  // R2
  tx_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[3]) |=> !tx_en_o);

  // R2
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr |=> $stable({rx_en_o, tx_en_o}));

  // R10
  tx_push_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> $past(wr_i && addr_i == ADDR_W'(OFS_DATA)));
endmodule

bind uart_chan_regs uart_chan_regs_chk #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .rx_en_o(rx_en_o), .tx_en_o(tx_en_o), .rx_reset_o(rx_reset_o), .tx_reset_o(tx_reset_o),
  .err_reset_o(err_reset_o), .brk_chg_reset_o(brk_chg_reset_o),
  .brk_start_o(brk_start_o), .brk_stop_o(brk_stop_o), .tx_push_o(tx_push_o)
);

// File: tb/tb_uart_chan_regs.sv
module tb_uart_chan_regs;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata, rx_data = '0, st = '0;
  logic rx_en, tx_en, rx_rst, tx_rst, err_rst, chg_rst, brk_on, brk_off;
  logic [1:0] char_len;
  logic [2:0] par_mode, baud_ext;
  logic [3:0] stop_sel;
  logic fifo_en, half_lvl, tx_push, rx_pop;
  logic [7:0] clk_sel, tx_data;

  int checks = 0, errors = 0;

  // model state
  int ptr = 1;
  logic [7:0] m0 = 0, m1 = 0, m2 = 0;
  logic erx = 0, etx = 0;

  always #10 clk = ~clk;

  uart_chan_regs dut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .rx_rdy_i(st[0]), .fifo_full_i(st[1]), .tx_rdy_i(st[2]),
    .tx_empty_i(st[3]), .overrun_i(st[4]), .par_err_i(st[5]), .frm_err_i(st[6]),
    .rx_brk_i(st[7]), .rx_data_i(rx_data), .rx_en_o(rx_en), .tx_en_o(tx_en),
    .rx_reset_o(rx_rst), .tx_reset_o(tx_rst), .err_reset_o(err_rst),
    .brk_chg_reset_o(chg_rst), .brk_start_o(brk_on), .brk_stop_o(brk_off),
    .char_len_o(char_len), .parity_mode_o(par_mode), .stop_sel_o(stop_sel),
    .baud_ext_o(baud_ext), .fifo_en_o(fifo_en), .tx_half_lvl_o(half_lvl),
    .clk_sel_o(clk_sel), .tx_push_o(tx_push), .tx_data_o(tx_data), .rx_pop_o(rx_pop)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_strobes(logic [3:0] code);
    return {code == 4'h2, code == 4'h3, code == 4'h4, code == 4'h5, code == 4'h6, code == 4'h7};
  endfunction

  function automatic logic [7:0] cur_mr();
    return (ptr == 0) ? m0 : (ptr == 1) ? m1 : m2;
  endfunction

  function automatic logic [7:0] fields();
    return 8'h00;
  endfunction

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic check_fields();
    // R7
    check("R7 char_len", char_len, m1[1:0]);
    check("R7 parity", par_mode, m1[4:2]);
    check("R7 stop", stop_sel, m2[3:0]);
    check("R7 baud_ext", baud_ext, m0[2:0]);
    check("R7 fifo_en", fifo_en, m0[3]);
    check("R7 half_lvl", half_lvl, m0[4]);
  endtask

  task automatic do_cmd(logic [7:0] d);
    logic [3:0] code;
    code = d[7:4];
    bus_wr(2'd2, d);
    if (code == 4'h2 || d[1]) erx = 0; else if (d[0]) erx = 1;
    if (code == 4'h3 || d[3]) etx = 0; else if (d[2]) etx = 1;
    if (code == 4'h1) ptr = 1;
    if (code == 4'hB) ptr = 0;
    // R2 R4
    check("R2/R4 rx_en", rx_en, erx);
    check("R2/R4 tx_en", tx_en, etx);
    // R3
    check("R3 strobes", {rx_rst, tx_rst, err_rst, chg_rst, brk_on, brk_off}, exp_strobes(code));
    @(negedge clk);
    check("R3 strobes drop", {rx_rst, tx_rst, err_rst, chg_rst, brk_on, brk_off}, 6'h0);
  endtask

  task automatic do_mode_wr(logic [7:0] d);
    bus_wr(2'd0, d);
    case (ptr)
      0: begin m0 = d; ptr = 1; end
      1: begin m1 = d; ptr = 2; end
      default: m2 = d;
    endcase
    check_fields();
  endtask

  task automatic do_read(logic [1:0] a);
    logic [7:0] e;
    st = 8'($urandom);
    rx_data = 8'($urandom);
    bus_rd(a);
    case (a)
      2'd0: e = cur_mr();
      2'd1: e = st;
      2'd2: e = {6'b0, etx, erx};
      default: e = rx_data;
    endcase
    // R5 R6 R8 R9 R10
    check("R8/R9/R10 rdata", rdata, e);
    check("R10 rx_pop", rx_pop, a == 2'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0ffee5));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 enables", {rx_en, tx_en}, 2'b00);
    check("R1 strobes", {rx_rst, tx_rst, err_rst, chg_rst, brk_on, brk_off, tx_push, rx_pop}, 8'h0);
    check_fields();
    do_read(2'd0);

    // R5 pointer sequence MR1 -> MR2 -> MR2
    do_mode_wr(8'h13);
    do_mode_wr(8'h07);
    do_mode_wr(8'h0F);
    check("R5 mr2 kept", stop_sel, 4'hF);
    do_read(2'd0);
    do_cmd(8'h10);
    do_read(2'd0);
    do_mode_wr(8'h0E);
    // R6 MR0 then MR1
    do_cmd(8'hB0);
    do_read(2'd0);
    do_mode_wr(8'h1D);
    do_read(2'd0);
    do_mode_wr(8'h02);
    // R2 disable wins, R4 reset beats enable
    do_cmd(8'h05);
    do_cmd(8'h03);
    do_cmd(8'h2D);
    do_cmd(8'h35);
    do_cmd(8'h05);
    do_read(2'd2);
    // R10 data and clock select
    bus_wr(2'd3, 8'hA5);
    check("R10 tx_push", tx_push, 1'b1);
    check("R10 tx_data", tx_data, 8'hA5);
    @(negedge clk);
    check("R10 tx_push drop", tx_push, 1'b0);
    bus_wr(2'd1, 8'hBB);
    check("R10 clk_sel", clk_sel, 8'hBB);
    do_read(2'd3);
    do_read(2'd1);

    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 6);
      d = 8'($urandom);
      case (op)
        0, 1: do_cmd(d);
        2: do_mode_wr(d);
        3: begin
          bus_wr(2'd3, d);
          check("R10 tx_data", tx_data, d);
          check("R10 tx_push", tx_push, 1'b1);
        end
        4: begin
          bus_wr(2'd1, d);
          check("R10 clk_sel", clk_sel, d);
        end
        default: do_read(2'($urandom));
      endcase
      // R8 rdata held while not reading
      if (op != 5) begin
        logic [7:0] held;
        held = rdata;
        @(negedge clk);
        check("R8 rdata held", rdata, held);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule